// File: doc/BRIEF.md
# Shift-Gain PI Loop Filter

This block is the loop filter of an all-digital phase-locked loop. Once per comparison window it takes the signed error from a phase/frequency detector and turns it into a signed 22-bit tune word for a numerically controlled oscillator. The tune word is the sum of two paths. A proportional path scales the current error. An integrator path accumulates the scaled error. Each path's gain is a power of two, chosen by a 5-bit setting, so each multiply is only a barrel shift.

Both gain settings may change between any two windows without touching the stored integrator. This lets a loop lock with a wide bandwidth and then narrow to a low cleaning bandwidth without a phase hit. A hold input freezes the integrator and the output while the detector upstream keeps running. An offset override drives the output from a user word, while the integrator keeps tracking the error behind it. Three flags report clamping at the gain inputs, in the integrator and at the output.

Top module: `pi_loop_filter`

## Requirements
- R1: While rst_ni is low, volt_o, the integrator and all three saturation flags are zero (offset override off).
- R2: The proportional term in fixed point with FRAC_W fraction bits is floor(err_i * 2^(G1-2)), where G1 is g_prop_i. This gives a gain of 2^(G1-2)/2^FRAC_W in output LSBs.
- R3: On each applied window the integrator (FRAC_W fraction bits) adds err_i * 2^(G2+1), where G2 is g_int_i. This gives a gain of 2^(G2+1)/2^FRAC_W.
- R4: A window is applied on a clock edge where win_i=1 and hold_i=0. The new tune word is floor((new integrator + proportional term) / 2^FRAC_W) and shows from the next cycle. Without an applied window, the integrator and the tune word keep their values.
- R5: A g_prop_i above 18 acts as 18, and a g_int_i above 20 acts as 20. sat_in_o is 1 after an applied window in which either setting was clamped, and 0 after one in which neither was.
- R6: The integrator saturates to the signed range of VOLT_W+FRAC_W bits. sat_int_o is 1 after an applied window that clamped it, and 0 otherwise.
- R7: The tune word saturates to the signed 22-bit range (-2097152 to 2097151). sat_out_o is 1 after an applied window whose sum was clamped, and 0 otherwise.
- R8: While hold_i=1, the integrator, the tune word and the flags do not change, whatever err_i and win_i do.
- R9: While ofs_en_i=1, volt_o equals ofs_val_i in the same cycle, and the integrator keeps updating on applied windows. When ofs_en_i falls, volt_o shows the filter's current tune word in that same cycle.
- R10: Changing g_prop_i or g_int_i leaves the stored integrator unchanged. Only the terms of later windows use the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_i | input | 1 | Window strobe; applies one filter update |
| err_i | input | ERR_W (21) | Signed detector error |
| g_prop_i | input | 5 | Proportional gain exponent setting |
| g_int_i | input | 5 | Integral gain exponent setting |
| hold_i | input | 1 | Freeze integrator, tune word and flags |
| ofs_en_i | input | 1 | Output override enable |
| ofs_val_i | input | VOLT_W (22) | Signed override value |
| volt_o | output | VOLT_W (22) | Signed tune word |
| sat_in_o | output | 1 | A gain setting was clamped in the last applied window |
| sat_int_o | output | 1 | The integrator was clamped in the last applied window |
| sat_out_o | output | 1 | The tune word was clamped in the last applied window |

## Verification
The gain settings are swept one at a time with errors of both signs. Sweeping the proportional setting with a small integral gain shows the off-by-two floor shift against a plain shift. Sweeping the integral setting shows the +1 offset and the running sum. Sparse strobes and held windows with a busy error input tell an update gated by the strobe from a free-running one. A mid-run gain change tells a preserved integrator from a reset one. The override windows check that the integrator keeps tracking underneath and that the filter's word comes back at once on release. Long runs at full error with the largest integral gain drive the integrator into both rails. These runs tell clamping from wraparound and separate the three flags.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int unsigned G1_MAX  = 18;  // top proportional setting
  localparam int unsigned G2_MAX  = 20;  // top integral setting
  localparam int unsigned P_DOWN  = 2;   // proportional exponent offset -2
  localparam int unsigned I_UP    = 1;   // integral exponent offset +1
  localparam int unsigned GAIN_W  = 5;
endpackage

// File: rtl/lf_gain_shift.sv
module lf_gain_shift #(
  parameter int unsigned ERR_W = 21,
  parameter int unsigned IW    = 50,
  parameter int unsigned GMAX  = 18,
  parameter int unsigned UP    = 0,
  parameter int unsigned DOWN  = 0
) (
  input  logic signed [ERR_W-1:0]       err_i,
  input  logic [lf_pkg::GAIN_W-1:0]     g_i,
  output logic signed [IW-1:0]          term_o,
  output logic                          clamp_o
);
  localparam logic [lf_pkg::GAIN_W-1:0] GLIM = lf_pkg::GAIN_W'(GMAX);

  logic [lf_pkg::GAIN_W-1:0] g_eff;
  logic signed [IW-1:0]      ext;
  logic signed [IW-1:0]      up_sh;

  always_comb begin
    clamp_o = (g_i > GLIM);
    g_eff   = clamp_o ? GLIM : g_i;
    ext     = IW'(err_i);
    up_sh   = ext <<< (32'(g_eff) + UP);
    term_o  = up_sh >>> DOWN;  // floor division for the negative offset
  end
endmodule

// File: rtl/lf_integrator.sv
module lf_integrator #(
  parameter int unsigned IW = 50
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic signed [IW-1:0] term_i,
  output logic signed [IW-1:0] int_o,
  output logic signed [IW-1:0] int_nxt_o,
  output logic                 sat_o
);
  localparam logic signed [IW-1:0] MAXV = {1'b0, {(IW-1){1'b1}}};
  localparam logic signed [IW-1:0] MINV = {1'b1, {(IW-1){1'b0}}};

  logic signed [IW:0]   sum;
  logic signed [IW-1:0] int_q;

  always_comb begin
    sum   = {int_q[IW-1], int_q} + {term_i[IW-1], term_i};
    sat_o = (sum[IW] != sum[IW-1]);
    if (!sat_o)       int_nxt_o = sum[IW-1:0];
    else if (sum[IW]) int_nxt_o = MINV;
    else              int_nxt_o = MAXV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    int_q <= '0;
    else if (upd_i) int_q <= int_nxt_o;
  end

  assign int_o = int_q;
endmodule

// File: rtl/lf_out_stage.sv
module lf_out_stage #(
  parameter int unsigned VOLT_W = 22,
  parameter int unsigned FRAC_W = 28
) (
  input  logic signed [VOLT_W+FRAC_W-1:0] int_i,
  input  logic signed [VOLT_W+FRAC_W-1:0] prop_i,
  output logic signed [VOLT_W-1:0]        volt_o,
  output logic                            sat_o
);
  localparam int unsigned IW = VOLT_W + FRAC_W;
  localparam logic signed [IW-1:0] MAXV = {1'b0, {(IW-1){1'b1}}};
  localparam logic signed [IW-1:0] MINV = {1'b1, {(IW-1){1'b0}}};

  logic signed [IW:0]   sum;
  logic signed [IW-1:0] fx;

  always_comb begin
    sum   = {int_i[IW-1], int_i} + {prop_i[IW-1], prop_i};
    sat_o = (sum[IW] != sum[IW-1]);
    if (!sat_o)       fx = sum[IW-1:0];
    else if (sum[IW]) fx = MINV;
    else              fx = MAXV;
    volt_o = fx[IW-1:FRAC_W];  // arithmetic floor of the fixed-point sum
  end
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter #(
  parameter int unsigned ERR_W  = 21,
  parameter int unsigned VOLT_W = 22,
  parameter int unsigned FRAC_W = 28
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           win_i,
  input  logic signed [ERR_W-1:0]        err_i,
  input  logic [lf_pkg::GAIN_W-1:0]      g_prop_i,
  input  logic [lf_pkg::GAIN_W-1:0]      g_int_i,
  input  logic                           hold_i,
  input  logic                           ofs_en_i,
  input  logic signed [VOLT_W-1:0]       ofs_val_i,
  output logic signed [VOLT_W-1:0]       volt_o,
  output logic                           sat_in_o,
  output logic                           sat_int_o,
  output logic                           sat_out_o
);
  localparam int unsigned IW = VOLT_W + FRAC_W;

  logic                    upd;
  logic signed [IW-1:0]    p_term, i_term, int_q, int_nxt;
  logic                    p_clamp, i_clamp, int_sat, out_sat;
  logic signed [VOLT_W-1:0] volt_nxt, volt_q;
  logic                    sat_in_q, sat_int_q, sat_out_q;

  assign upd = win_i & ~hold_i;

  lf_gain_shift #(.ERR_W(ERR_W), .IW(IW), .GMAX(lf_pkg::G1_MAX),
                  .UP(0), .DOWN(lf_pkg::P_DOWN)) u_prop (
    .err_i(err_i), .g_i(g_prop_i), .term_o(p_term), .clamp_o(p_clamp));

  lf_gain_shift #(.ERR_W(ERR_W), .IW(IW), .GMAX(lf_pkg::G2_MAX),
                  .UP(lf_pkg::I_UP), .DOWN(0)) u_intg (
    .err_i(err_i), .g_i(g_int_i), .term_o(i_term), .clamp_o(i_clamp));

  lf_integrator #(.IW(IW)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd), .term_i(i_term),
    .int_o(int_q), .int_nxt_o(int_nxt), .sat_o(int_sat));

  lf_out_stage #(.VOLT_W(VOLT_W), .FRAC_W(FRAC_W)) u_out (
    .int_i(int_nxt), .prop_i(p_term), .volt_o(volt_nxt), .sat_o(out_sat));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      volt_q    <= '0;
      sat_in_q  <= 1'b0;
      sat_int_q <= 1'b0;
      sat_out_q <= 1'b0;
    end else if (upd) begin
      volt_q    <= volt_nxt;
      sat_in_q  <= p_clamp | i_clamp;
      sat_int_q <= int_sat;
      sat_out_q <= out_sat;
    end
  end

  // override is combinational so release is seen in the same cycle
  assign volt_o    = ofs_en_i ? ofs_val_i : volt_q;
  assign sat_in_o  = sat_in_q;
  assign sat_int_o = sat_int_q;
  assign sat_out_o = sat_out_q;
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int unsigned IW     = 50,
  parameter int unsigned VOLT_W = 22
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     win_i,
  input logic                     hold_i,
  input logic [4:0]               g_prop_i,
  input logic [4:0]               g_int_i,
  input logic signed [IW-1:0]     int_q,
  input logic signed [VOLT_W-1:0] volt_q,
  input logic                     sat_in_o,
  input logic                     sat_int_o,
  input logic                     sat_out_o
);
  localparam logic signed [IW-1:0]     IMAX = {1'b0, {(IW-1){1'b1}}};
  localparam logic signed [IW-1:0]     IMIN = {1'b1, {(IW-1){1'b0}}};
  localparam logic signed [VOLT_W-1:0] VMAX = {1'b0, {(VOLT_W-1){1'b1}}};
  localparam logic signed [VOLT_W-1:0] VMIN = {1'b1, {(VOLT_W-1){1'b0}}};

  p_hold_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(int_q) && $stable(volt_q) && $stable(sat_int_o)));

  p_idle_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_i |=> ($stable(int_q) && $stable(volt_q)));

  p_int_rail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_int_o |-> (int_q == IMAX || int_q == IMIN));

  p_out_rail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_out_o |-> (volt_q == VMAX || volt_q == VMIN));

  p_gain_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i && !hold_i && g_prop_i <= 5'd18 && g_int_i <= 5'd20) |=> !sat_in_o);
endmodule

bind pi_loop_filter lf_checker #(.IW(IW), .VOLT_W(VOLT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .win_i(win_i), .hold_i(hold_i),
  .g_prop_i(g_prop_i), .g_int_i(g_int_i), .int_q(int_q), .volt_q(volt_q),
  .sat_in_o(sat_in_o), .sat_int_o(sat_int_o), .sat_out_o(sat_out_o));

// File: tb/sim_pi_loop_filter.sv
`timescale 1ns/1ps
module sim_pi_loop_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win = 1'b0, hold = 1'b0, ofs_en = 1'b0;
  logic signed [20:0] err = '0;
  logic [4:0] g1 = 5'd0, g2 = 5'd1;
  logic signed [21:0] ofs_val = '0;
  logic signed [21:0] volt;
  logic s_in, s_int, s_out;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  pi_loop_filter u0 (
    .clk_i(clk), .rst_ni(rst_n), .win_i(win), .err_i(err),
    .g_prop_i(g1), .g_int_i(g2), .hold_i(hold), .ofs_en_i(ofs_en),
    .ofs_val_i(ofs_val), .volt_o(volt), .sat_in_o(s_in),
    .sat_int_o(s_int), .sat_out_o(s_out));

  // behavioural reference
  localparam longint IMAX = (longint'(1) <<< 49) - 1;
  localparam longint IMIN = -(longint'(1) <<< 49);
  longint m_int = 0, m_volt = 0;
  bit m_sin = 0, m_sint = 0, m_sout = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_int = 0; m_volt = 0; m_sin = 0; m_sint = 0; m_sout = 0;
    end else if (win && !hold) begin
      int ge1, ge2;
      longint e, p, s, o;
      ge1 = (g1 > 18) ? 18 : int'(g1);
      ge2 = (g2 > 20) ? 20 : int'(g2);
      e = longint'(err);
      p = (e * (longint'(1) <<< ge1)) >>> 2;
      s = m_int + e * (longint'(1) <<< (ge2 + 1));
      m_sint = (s > IMAX) || (s < IMIN);
      m_int = (s > IMAX) ? IMAX : (s < IMIN) ? IMIN : s;
      o = m_int + p;
      m_sout = (o > IMAX) || (o < IMIN);
      o = (o > IMAX) ? IMAX : (o < IMIN) ? IMIN : o;
      m_volt = o >>> 28;
      m_sin = (g1 > 18) || (g2 > 20);
    end
  end

  task automatic check_all();
    longint exp_v;
    exp_v = ofs_en ? longint'(ofs_val) : m_volt;
    checks++;
    if (longint'(volt) != exp_v) begin
      fails++;
      $display("FAIL %s volt actual=%0d expected=%0d", tag, volt, exp_v);
    end
    checks++;
    if ({s_in, s_int, s_out} != {m_sin, m_sint, m_sout}) begin
      fails++;
      $display("FAIL %s flags actual=%b%b%b expected=%b%b%b", tag,
               s_in, s_int, s_out, m_sin, m_sint, m_sout);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  function automatic logic signed [20:0] rnd_err(int span);
    return 21'($signed($urandom_range(2 * span, 0)) - span);
  endfunction

  initial begin
    repeat (3) step();                 // R1 reset state
    rst_n = 1'b1;
    step();

    tag = "R2";                        // proportional sweep
    g2 = 5'd0;
    for (int g = 0; g <= 18; g++) begin
      g1 = 5'(g); win = 1'b1;
      err = (g % 2 == 0) ? 21'sd1000003 : -21'sd777777;
      step();
    end

    tag = "R3";                        // integral sweep
    g1 = 5'd0;
    for (int g = 0; g <= 20; g++) begin
      g2 = 5'(g); err = rnd_err(4000); step();
      err = -err; step();
    end

    tag = "R4";                        // sparse strobes
    g1 = 5'd10; g2 = 5'd12;
    for (int k = 0; k < 60; k++) begin
      win = (k % 3 == 0); err = rnd_err(500000); step();
    end

    tag = "R10";                       // gain change mid-run
    win = 1'b1; err = 21'sd20000;
    for (int k = 0; k < 10; k++) step();
    g1 = 5'd2; g2 = 5'd3;
    for (int k = 0; k < 10; k++) step();

    tag = "R8";                        // hold
    hold = 1'b1;
    for (int k = 0; k < 30; k++) begin
      win = k[0]; err = rnd_err(1000000); g1 = 5'd31; step();
    end
    hold = 1'b0; g1 = 5'd6; win = 1'b1; step();

    tag = "R9";                        // offset override
    ofs_en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      ofs_val = 22'($signed($urandom_range(4000000, 0)) - 2000000);
      err = rnd_err(300000); step();
    end
    ofs_en = 1'b0; win = 1'b0; step();
    win = 1'b1; step();

    tag = "R5";                        // gain clamp
    g1 = 5'd31; g2 = 5'd20; step();
    g1 = 5'd18; g2 = 5'd25; step();
    g1 = 5'd19; g2 = 5'd21; step();
    g1 = 5'd18; g2 = 5'd20; step();

    tag = "R6";                        // drive to positive rail
    g1 = 5'd18; g2 = 5'd20; err = 21'sd1048575;
    for (int k = 0; k < 300; k++) step();
    tag = "R7";
    for (int k = 0; k < 5; k++) step();
    tag = "R6";                        // then to negative rail
    err = -21'sd1048576;
    for (int k = 0; k < 600; k++) step();
    tag = "R7";
    g1 = 5'd0; err = 21'sd4;
    for (int k = 0; k < 5; k++) step();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule